// File: doc/BRIEF.md
# Peripheral Request Channel Router

This block sits between a set of peripheral request lines and the channels of a DMA engine. Each of the 75 request lines has a small programmable map entry that says which channel it feeds and whether the mapping is in force. The block synchronises the raw request lines, merges every enabled request that targets a channel into one request-active level for that channel, and watches that level for edges. When a channel's level goes from inactive to active, the block emits a one-cycle request-after-stop event. When the level goes from active to inactive, it emits a one-cycle end-of-receive event. The status block uses the same pulse to clear its request-after-stop flag.

Software programs the map entries through a simple write/read port. The entries live in two address windows. Requests 0 to 63 sit at byte offset 0x100 + 4n, and requests 64 to 74 sit at 0x1100 + 4(n-64). A write that enables a mapping to a channel the configuration does not have is refused. The entry keeps its old value, and a sticky error flag rises. The channel transfer engine and interrupt merging are outside this block.

Top module: `dreq_chan_router`

## Requirements
- R1: After reset every channel level, every event pulse and the error flag are 0, and every map entry reads back as 0.
- R2: A write with cfg_addr = 0x100 + 4n (n = 0..63) stores cfg_wdata in the entry of request n, and a read at that address returns it on cfg_rdata in the same cycle.
- R3: A write with cfg_addr = 0x1100 + 4(n-64) (n = 64..74) stores the entry of request n. Writes to any other address, including 0x112C and misaligned offsets, change no entry, and reads of such addresses return 0.
- R4: In a map entry, bits [4:0] select the channel and bit 7 enables the mapping. A channel's level is the OR of all synchronised requests whose entry is enabled and selects it. The level changes on the third rising clock edge after the request input changes.
- R5: A request whose entry has bit 7 clear never raises any channel level or event.
- R6: When a channel level goes from 0 to 1, ras_evt_o for that channel is 1 for exactly the cycle in which the level first reads 1.
- R7: When a channel level goes from 1 to 0, eor_evt_o for that channel is 1 for exactly the cycle in which the level first reads 0. The two pulses are never high together.
- R8: A write with bit 7 set and a channel field of NUM_CH or more leaves the entry unchanged and sets map_err_o, which stays set until reset. Such a field with bit 7 clear is stored without error.
- R9: A request that turns on or off while another request keeps the same channel active produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_REQ | Raw peripheral request lines |
| cfg_we | input | 1 | Map write strobe |
| cfg_addr | input | 13 | Byte address of the map access |
| cfg_wdata | input | 8 | Map write data |
| cfg_rdata | output | 8 | Map read data for cfg_addr (combinational) |
| map_err_o | output | 1 | Sticky illegal-mapping flag |
| ch_active_o | output | NUM_CH | Per-channel request-active level |
| ras_evt_o | output | NUM_CH | Request-after-stop event pulses |
| eor_evt_o | output | NUM_CH | End-of-receive event pulses |

## Verification
A request input change reaches ch_active_o and the event pulses on the third rising edge after it. The bench drives the request on a falling edge, waits three rising edges and samples on the next falling edge. It then samples one cycle later to confirm that the pulse has ended. A map write takes effect on the rising edge that captures the strobe. The bench checks map_err_o and the read-back value on the following falling edge, and cfg_rdata is read combinationally shortly after the address is driven. The absence of an event is confirmed by sampling every cycle across the whole window in which a wrong pulse would appear.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    // Map entry layout: bit 7 enables the mapping, bits 4:0 pick the channel.
    typedef struct packed {
        logic       valid;
        logic [1:0] spare;
        logic [4:0] ch;
    } map_entry_t;

    localparam int          ADDR_W    = 13;
    localparam int          LO_COUNT  = 64;
    localparam logic [4:0]  LO_PAGE   = 5'h01;  // 0x100 .. 0x1FC
    localparam logic [4:0]  HI_PAGE   = 5'h11;  // 0x1100 ..

endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/dcr_map_regs.sv
module dcr_map_regs
    import dcr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [ADDR_W-1:0]            cfg_addr,
    input  logic [7:0]                   cfg_wdata,
    output logic [7:0]                   cfg_rdata,
    output logic                         err_o,
    output map_entry_t [NUM_REQ-1:0]     map_o
);

    localparam int IDX_W    = $clog2(NUM_REQ);
    localparam int HI_COUNT = NUM_REQ - LO_COUNT;

    typedef struct packed {
        map_entry_t [NUM_REQ-1:0] map;
        logic                     err;
    } regs_t;

    regs_t st_d, st_q;

    logic [5:0]       slot;
    logic             lo_hit, hi_hit, hit, illegal;
    logic [IDX_W-1:0] idx;
    map_entry_t       wentry;

    always_comb begin
        slot    = cfg_addr[7:2];
        lo_hit  = (cfg_addr[12:8] == LO_PAGE) && (cfg_addr[1:0] == 2'b00);
        hi_hit  = (cfg_addr[12:8] == HI_PAGE) && (cfg_addr[1:0] == 2'b00) &&
                  (int'(slot) < HI_COUNT);
        hit     = lo_hit || hi_hit;
        idx     = lo_hit ? IDX_W'(slot) : IDX_W'(slot) + IDX_W'(LO_COUNT);
        wentry  = map_entry_t'(cfg_wdata);
        illegal = wentry.valid && ({1'b0, wentry.ch} >= 6'(NUM_CH));

        st_d = st_q;
        if (cfg_we && hit) begin
            if (illegal) st_d.err = 1'b1;
            else         st_d.map[idx] = wentry;
        end

        cfg_rdata = hit ? 8'(st_q.map[idx]) : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;
    assign map_o = st_q.map;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    assert_illegal_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && hit && illegal) |=> ($stable(st_q.map) && st_q.err));

    generate
        for (genvar r = 0; r < NUM_REQ; r++) begin : g_range
            assert_entry_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.map[r].valid |-> ({1'b0, st_q.map[r].ch} < 6'(NUM_CH)));
        end
    endgenerate

endmodule

// File: rtl/dcr_chan_combine.sv
module dcr_chan_combine
    import dcr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       sreq_i,
    input  map_entry_t [NUM_REQ-1:0] map_i,
    output logic [NUM_CH-1:0]        active_o,
    output logic [NUM_CH-1:0]        rise_o,
    output logic [NUM_CH-1:0]        fall_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] lvl;
        logic [NUM_CH-1:0] rise;
        logic [NUM_CH-1:0] fall;
    } edge_t;

    edge_t             st_d, st_q;
    logic [NUM_CH-1:0] lvl_now;

    always_comb begin
        lvl_now = '0;
        for (int r = 0; r < NUM_REQ; r++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (sreq_i[r] && map_i[r].valid && (int'(map_i[r].ch) == c))
                    lvl_now[c] = 1'b1;
            end
        end
        st_d      = st_q;
        st_d.lvl  = lvl_now;
        st_d.rise = lvl_now & ~st_q.lvl;
        st_d.fall = ~lvl_now & st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.lvl;
    assign rise_o   = st_q.rise;
    assign fall_o   = st_q.fall;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            assert_rise_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[c] |-> (active_o[c] && !$past(active_o[c])));
            assert_fall_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
                fall_o[c] |-> (!active_o[c] && $past(active_o[c])));
            assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[c] |=> !rise_o[c]);
        end
    endgenerate

    assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & fall_o) == '0);

endmodule

// File: rtl/dreq_chan_router.sv
module dreq_chan_router
    import dcr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               cfg_we,
    input  logic [12:0]        cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic               map_err_o,
    output logic [NUM_CH-1:0]  ch_active_o,
    output logic [NUM_CH-1:0]  ras_evt_o,
    output logic [NUM_CH-1:0]  eor_evt_o
);

    logic [NUM_REQ-1:0]       sreq;
    map_entry_t [NUM_REQ-1:0] map;

    dcr_sync #(.WIDTH(NUM_REQ)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_i),
        .q_o   (sreq)
    );

    dcr_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .err_o     (map_err_o),
        .map_o     (map)
    );

    dcr_chan_combine #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) comb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sreq_i   (sreq),
        .map_i    (map),
        .active_o (ch_active_o),
        .rise_o   (ras_evt_o),
        .fall_o   (eor_evt_o)
    );

endmodule

// File: tb/dreq_chan_router_tb_top.sv
module dreq_chan_router_tb_top;

    localparam int NREQ = 75;
    localparam int NCH  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req_i = '0;
    logic            cfg_we = 1'b0;
    logic [12:0]     cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [7:0]      cfg_rdata;
    logic            map_err_o;
    logic [NCH-1:0]  ch_active_o, ras_evt_o, eor_evt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dreq_chan_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut_i (
        .clk, .rst_n, .req_i, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .map_err_o, .ch_active_o, .ras_evt_o, .eor_evt_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] addr_of(input int n);
        return (n < 64) ? 13'(32'h100 + 4 * n) : 13'(32'h1100 + 4 * (n - 64));
    endfunction

    function automatic logic [3:0] ch_of(input int n);
        return 4'((n * 7) % NCH);
    endfunction

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // drive a request on a falling edge, sample on the falling edge after the third rising edge
    task automatic drive_req(input int r, input logic v);
        @(negedge clk);
        req_i[r] = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active", 32'(ch_active_o), 0);
        chk("R1 ras", 32'(ras_evt_o), 0);
        chk("R1 eor", 32'(eor_evt_o), 0);
        chk("R1 err", 32'(map_err_o), 0);
        for (int n = 0; n < NREQ; n++) begin
            rd(addr_of(n), d);
            chk("R1 entry", 32'(d), 0);
        end

        // program every entry through both windows
        for (int n = 0; n < NREQ; n++) wr(addr_of(n), 8'h80 | 8'(ch_of(n)));
        for (int n = 0; n < NREQ; n++) begin
            rd(addr_of(n), d);
            chk(n < 64 ? "R2 readback" : "R3 readback", 32'(d), 32'(8'h80 | 8'(ch_of(n))));
        end

        // writes outside the windows
        wr(13'h112C, 8'h85);
        wr(13'h0101, 8'h8F);
        wr(13'h1000, 8'h81);
        rd(13'h112C, d); chk("R3 hole read", 32'(d), 0);
        rd(13'h0101, d); chk("R3 misaligned read", 32'(d), 0);
        rd(addr_of(0), d);  chk("R3 entry0 kept", 32'(d), 32'h80);
        rd(addr_of(11), d); chk("R3 entry11 kept", 32'(d), 32'(8'h80 | 8'(ch_of(11))));
        rd(addr_of(64), d); chk("R3 entry64 kept", 32'(d), 32'(8'h80 | 8'(ch_of(64))));

        // sweep each request through its channel
        for (int r = 0; r < NREQ; r++) begin
            drive_req(r, 1'b1);
            chk("R4 level on", 32'(ch_active_o), 32'(1) << ch_of(r));
            chk("R6 ras pulse", 32'(ras_evt_o), 32'(1) << ch_of(r));
            chk("R7 no eor on rise", 32'(eor_evt_o), 0);
            @(negedge clk);
            chk("R6 ras ends", 32'(ras_evt_o), 0);
            drive_req(r, 1'b0);
            chk("R4 level off", 32'(ch_active_o), 0);
            chk("R7 eor pulse", 32'(eor_evt_o), 32'(1) << ch_of(r));
            chk("R7 no ras on fall", 32'(ras_evt_o), 0);
            @(negedge clk);
            chk("R7 eor ends", 32'(eor_evt_o), 0);
        end

        // illegal mapping
        chk("R8 err clear before", 32'(map_err_o), 0);
        wr(addr_of(10), 8'h90);
        chk("R8 err set", 32'(map_err_o), 1);
        rd(addr_of(10), d); chk("R8 entry kept", 32'(d), 32'(8'h80 | 8'(ch_of(10))));
        wr(addr_of(70), 8'h9F);
        rd(addr_of(70), d); chk("R8 entry70 kept", 32'(d), 32'(8'h80 | 8'(ch_of(70))));
        wr(addr_of(12), 8'h14);
        rd(addr_of(12), d); chk("R8 disabled big ch stored", 32'(d), 32'h14);
        wr(addr_of(13), 8'h8F);
        rd(addr_of(13), d); chk("R8 top channel stored", 32'(d), 32'h8F);
        chk("R8 err sticky", 32'(map_err_o), 1);

        // disabled mapping has no effect
        wr(addr_of(5), 8'h02);
        @(negedge clk);
        req_i[5] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R5 level", 32'(ch_active_o), 0);
            chk("R5 ras", 32'(ras_evt_o), 0);
        end
        req_i[5] = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R5 eor", 32'(eor_evt_o), 0);
        end

        // two requests sharing channel 3
        wr(addr_of(1), 8'h83);
        wr(addr_of(66), 8'h83);
        drive_req(1, 1'b1);
        chk("R9 first ras", 32'(ras_evt_o), 32'h8);
        @(negedge clk);
        req_i[66] = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R9 no ras on join", 32'(ras_evt_o), 0);
            chk("R9 level held", 32'(ch_active_o), 32'h8);
        end
        req_i[1] = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R9 no eor on leave", 32'(eor_evt_o), 0);
            chk("R9 level kept", 32'(ch_active_o), 32'h8);
        end
        drive_req(66, 1'b0);
        chk("R9 final eor", 32'(eor_evt_o), 32'h8);
        chk("R9 level dropped", 32'(ch_active_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule